// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Detection and Glitch-Free Pump Settings

This block is the digital core of a synthesizer loop's phase comparator. It watches two divider outputs, a reference edge stream and a feedback (main divider) edge stream. Both are sampled and edge-detected on one system clock. It drives two pump-enable pulses. The pump-up pulse starts when the reference edge arrives first, and the pump-down pulse starts when the feedback edge arrives first. Both clear as soon as the trailing edge arrives. This is the classic three-state detector.

The block also carries the pump configuration: a 2-bit current-level code and an off (tri-state) control. Software writes these through a register interface that ends each transaction with a one-cycle done strobe. The strobe loads the values into a pending holder. The pending value is copied to the outputs only when neither pump pulse is high and no divider edge is arriving in that cycle. As a result, a level change never cuts into a pulse.

A lock detector measures each comparison's phase error as the number of clock cycles a pump pulse stays high. It declares lock after seven consecutive comparisons whose error is under a programmable window. Switching the pump off forces the pulses and the lock flag low and clears the detector's progress.

Top module: `pfd_lock_top`

## Requirements
- R1: When a reference rising edge precedes the feedback rising edge by N clock cycles, `pump_up` is high for exactly N cycles and `pump_dn` stays low.
- R2: When a feedback rising edge precedes the reference rising edge by N clock cycles, `pump_dn` is high for exactly N cycles and `pump_up` stays low.
- R3: `pump_up` and `pump_dn` are never high together. Rising edges that reach both inputs in the same cycle produce no pulse.
- R4: Values on `cfg_cur_sel`/`cfg_tristate` are ignored until `cfg_wr_done` is pulsed. After a strobe taken while the pump is idle, the new values appear on `pump_cur_sel`/`pump_tristate` by the second following clock edge. `pump_cur_sel` is the level code, 2'b00 lowest to 2'b11 highest.
- R5: A setting strobed while a pump pulse is high does not reach the outputs during that pulse. It is applied after the pulse ends, and `pump_cur_sel` never changes in a cycle where `pump_up` or `pump_dn` is high.
- R6: Phase error is the number of cycles a pump pulse is high in one comparison. `lock` goes high after seven consecutive comparisons each with error below `LOCK_WIN`, and not after six.
- R7: A comparison whose error is `LOCK_WIN` or more clears `lock` and restarts the count. An error of exactly `LOCK_WIN-1` still counts as in-window.
- R8: While `pump_tristate` is 1, both `pump_up` and `pump_dn` stay low whatever the divider inputs do.
- R9: While `pump_tristate` is 1, `lock` is low and the consecutive-comparison count is cleared. After the pump is turned back on, a full seven in-window comparisons are again needed.
- R10: During and after an active-low synchronous reset (with no further stimulus), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference divider output (asynchronous) |
| fb_in | input | 1 | Feedback divider output (asynchronous) |
| cfg_cur_sel | input | 2 | Requested pump current level code |
| cfg_tristate | input | 1 | Requested pump off control |
| cfg_wr_done | input | 1 | One-cycle strobe marking a finished configuration write |
| pump_up | output | 1 | Pump source enable |
| pump_dn | output | 1 | Pump sink enable |
| pump_cur_sel | output | 2 | Applied pump current level code |
| pump_tristate | output | 1 | Applied pump off state |
| lock | output | 1 | Loop locked indication |

## Verification
The bench builds the block with `LOCK_WIN` set to 8, keeping `LOCK_COUNT` at 7 and two synchronizer stages. With the window at 8, both sides of the window boundary (errors of 7 and 8 cycles) are produced with short edge offsets. A whole lock/unlock sequence therefore fits in a few hundred cycles. Long offsets of 20 cycles keep a pump pulse open long enough to strobe a configuration mid-pulse and watch it held back.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int CUR_W = 2;

  typedef struct packed {
    logic [CUR_W-1:0] cur;
    logic             off;
  } pump_cfg_t;
endpackage

// File: rtl/pfd_edge_rise.sv
module pfd_edge_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  input  logic pump_off,
  output logic up,
  output logic dn,
  output logic cmp_evt,
  output logic quiet
);
  logic up_nx, dn_nx, both;

  always_comb begin
    up_nx = up | ref_rise;
    dn_nx = dn | fb_rise;
    both  = up_nx & dn_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pump_off) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (both) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_nx;
      dn <= dn_nx;
    end
  end

  assign cmp_evt = both & ~pump_off;
  assign quiet   = ~(up | dn | ref_rise | fb_rise);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn)); // R3
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pump_off |-> (!up && !dn)); // R8
  AST_UP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(ref_rise)); // R1
  AST_DN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(fb_rise)); // R2
endmodule

// File: rtl/pfd_cfg_hold.sv
module pfd_cfg_hold
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_done,
  input  pump_cfg_t cfg_in,
  input  logic      quiet,
  input  logic      up,
  input  logic      dn,
  output pump_cfg_t cfg_out
);
  pump_cfg_t pend_q;
  logic      pend_v;
  logic      apply;

  assign apply = pend_v & quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pend_v  <= 1'b0;
      cfg_out <= '0;
    end else begin
      if (wr_done) begin
        pend_q <= cfg_in;
        pend_v <= 1'b1;
      end else if (apply) begin
        pend_v <= 1'b0;
      end
      if (apply) cfg_out <= pend_q;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out.cur) |-> (!up && !dn)); // R5
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out.off) |-> (!up && !dn)); // R5
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int LOCK_WIN   = 25,
  parameter int LOCK_COUNT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cmp_evt,
  input  logic pump_off,
  output logic lock
);
  localparam int ERR_W  = $clog2(LOCK_WIN + 1);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam logic [ERR_W-1:0]  RUN_MAX = ERR_W'(LOCK_WIN);
  localparam logic [ERR_W:0]    WIN_LIM = (ERR_W+1)'(LOCK_WIN);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_COUNT);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);

  logic [ERR_W-1:0]  run_q;
  logic [GOOD_W-1:0] good_q;
  logic [ERR_W:0]    err;
  logic              in_win;

  assign err    = {1'b0, run_q} + {{ERR_W{1'b0}}, active};
  assign in_win = err < WIN_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n || pump_off) begin
      run_q  <= '0;
      good_q <= '0;
      lock   <= 1'b0;
    end else begin
      if (cmp_evt) run_q <= '0;
      else if (active && run_q != RUN_MAX) run_q <= run_q + 1'b1;
      if (cmp_evt) begin
        if (in_win) begin
          if (good_q != GOOD_MAX) good_q <= good_q + 1'b1;
          lock <= (good_q >= GOOD_LAST);
        end else begin
          good_q <= '0;
          lock   <= 1'b0;
        end
      end
    end
  end

  AST_LOCK_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(cmp_evt)); // R6
  AST_WIDE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && !in_win) |=> !lock); // R7
  AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_off && $past(pump_off)) |-> !lock); // R9
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_WIN    = 25,
  parameter int LOCK_COUNT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [CUR_W-1:0] cfg_cur_sel,
  input  logic             cfg_tristate,
  input  logic             cfg_wr_done,
  output logic             pump_up,
  output logic             pump_dn,
  output logic [CUR_W-1:0] pump_cur_sel,
  output logic             pump_tristate,
  output logic             lock
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise;
  logic           cmp_evt, quiet;
  pump_cfg_t      cfg_req, cfg_now;

  assign raw_in = {fb_in, ref_in};

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    pfd_edge_rise #(.STAGES(SYNC_STAGES)) u_edge (
      .clk (clk),
      .rst_n (rst_n),
      .din (raw_in[g]),
      .rise (rise[g])
    );
  end

  pfd_core u_core (
    .clk (clk),
    .rst_n (rst_n),
    .ref_rise (rise[0]),
    .fb_rise (rise[1]),
    .pump_off (cfg_now.off),
    .up (pump_up),
    .dn (pump_dn),
    .cmp_evt (cmp_evt),
    .quiet (quiet)
  );

  assign cfg_req.cur = cfg_cur_sel;
  assign cfg_req.off = cfg_tristate;

  pfd_cfg_hold u_cfg (
    .clk (clk),
    .rst_n (rst_n),
    .wr_done (cfg_wr_done),
    .cfg_in (cfg_req),
    .quiet (quiet),
    .up (pump_up),
    .dn (pump_dn),
    .cfg_out (cfg_now)
  );

  pfd_lock_det #(.LOCK_WIN(LOCK_WIN), .LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk (clk),
    .rst_n (rst_n),
    .active (pump_up | pump_dn),
    .cmp_evt (cmp_evt),
    .pump_off (cfg_now.off),
    .lock (lock)
  );

  assign pump_cur_sel  = cfg_now.cur;
  assign pump_tristate = cfg_now.off;
endmodule

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0, fb_in = 1'b0;
  logic [1:0] cfg_cur_sel = 2'b00;
  logic       cfg_tristate = 1'b0, cfg_wr_done = 1'b0;
  logic       pump_up, pump_dn, pump_tristate, lock;
  logic [1:0] pump_cur_sel;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock_top #(.SYNC_STAGES(2), .LOCK_WIN(WIN), .LOCK_COUNT(7)) dut (
    .clk (clk), .rst_n (rst_n), .ref_in (ref_in), .fb_in (fb_in),
    .cfg_cur_sel (cfg_cur_sel), .cfg_tristate (cfg_tristate),
    .cfg_wr_done (cfg_wr_done), .pump_up (pump_up), .pump_dn (pump_dn),
    .pump_cur_sel (pump_cur_sel), .pump_tristate (pump_tristate), .lock (lock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // lead > 0: reference first; lead < 0: feedback first
  task automatic compare(input int lead, output int upw, output int dnw);
    int rs, fs;
    rs = (lead < 0) ? -lead : 0;
    fs = (lead > 0) ? lead : 0;
    upw = 0;
    dnw = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pump_up) upw++;
      if (pump_dn) dnw++;
      ref_in = (i >= rs) && (i < 30);
      fb_in  = (i >= fs) && (i < 30);
    end
  endtask

  task automatic write_cfg(input logic [1:0] cur, input logic off);
    @(negedge clk);
    cfg_cur_sel  = cur;
    cfg_tristate = off;
    cfg_wr_done  = 1'b1;
    @(negedge clk);
    cfg_wr_done  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_good(input int n);
    int u, d;
    for (int k = 0; k < n; k++) compare(2, u, d);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pump_up && !pump_dn, "R10 pumps idle", int'(pump_up) + int'(pump_dn), 0);
    chk(pump_cur_sel == 2'b00 && !pump_tristate, "R10 cfg reset",
        int'({pump_cur_sel, pump_tristate}), 0);
    chk(!lock, "R10 lock reset", int'(lock), 0);
  endtask

  task automatic t_phase;
    int u, d;
    compare(5, u, d);
    chk(u == 5, "R1 up width", u, 5);
    chk(d == 0, "R1 dn quiet", d, 0);
    compare(-3, u, d);
    chk(d == 3, "R2 dn width", d, 3);
    chk(u == 0, "R2 up quiet", u, 0);
    compare(0, u, d);
    chk(u + d == 0, "R3 coincident edges", u + d, 0);
  endtask

  task automatic t_cfg_idle;
    @(negedge clk);
    cfg_cur_sel = 2'b11;
    repeat (4) @(negedge clk);
    chk(pump_cur_sel == 2'b00, "R4 no strobe ignored", pump_cur_sel, 0);
    cfg_cur_sel = 2'b10;
    cfg_wr_done = 1'b1;
    @(negedge clk);
    cfg_wr_done = 1'b0;
    @(negedge clk);
    chk(pump_cur_sel == 2'b10, "R4 applied when idle", pump_cur_sel, 2);
  endtask

  task automatic t_cfg_defer;
    bit up_seen;
    logic [1:0] held;
    up_seen = 1'b0;
    held = 2'b10;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 15) begin
        up_seen = pump_up;
        held = pump_cur_sel;
      end
      ref_in = (i < 30);
      fb_in  = (i >= 20) && (i < 30);
      cfg_cur_sel = 2'b01;
      cfg_wr_done = (i == 8);
    end
    chk(up_seen, "R5 pulse open mid-write", int'(up_seen), 1);
    chk(held == 2'b10, "R5 held during pulse", held, 2);
    chk(pump_cur_sel == 2'b01, "R5 applied after pulse", pump_cur_sel, 1);
  endtask

  task automatic t_lock;
    int u, d;
    compare(12, u, d);
    chk(!lock, "R7 wide error no lock", int'(lock), 0);
    run_good(6);
    chk(!lock, "R6 six not enough", int'(lock), 0);
    compare(WIN - 1, u, d);
    chk(lock, "R6 seventh in-window (R7 boundary)", int'(lock), 1);
    compare(WIN, u, d);
    chk(!lock, "R7 error at window unlocks", int'(lock), 0);
    run_good(6);
    chk(!lock, "R7 restart count", int'(lock), 0);
    run_good(1);
    chk(lock, "R7 relock after seven", int'(lock), 1);
  endtask

  task automatic t_tristate;
    int u, d;
    write_cfg(2'b01, 1'b1);
    chk(pump_tristate, "R8 off applied", int'(pump_tristate), 1);
    chk(!lock, "R9 lock dropped", int'(lock), 0);
    compare(5, u, d);
    chk(u + d == 0, "R8 pumps held low", u + d, 0);
    write_cfg(2'b01, 1'b0);
    compare(12, u, d);
    run_good(6);
    write_cfg(2'b01, 1'b1);
    write_cfg(2'b01, 1'b0);
    run_good(1);
    chk(!lock, "R9 count cleared by off", int'(lock), 0);
    run_good(6);
    chk(lock, "R9 full count after on", int'(lock), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_phase();
    t_cfg_idle();
    t_cfg_defer();
    t_lock();
    t_tristate();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule